// File: doc/BRIEF.md
# Greedy Spare Coverage Selector

The block picks spare elements (rows and columns of a repairable memory) that together cover the faulty cells. It does this in one pass. Each candidate spare arrives as a bit vector with one bit per fault. A bit is set when that spare repairs that fault. The block keeps a register of faults that are already covered. For each candidate it decides in one cycle whether the candidate repairs at least one fault that is not yet covered. That decision bit is shifted into a selection register, and the candidate's faults are merged into the coverage register.

A pulse on `start` begins a pass. Candidates are then presented one per cycle with a valid strobe, and the final one carries a last flag. When the pass ends, `done` rises and stays high. The selection vector holds one bit per candidate, with the oldest candidate in the highest occupied position. A separate flag reports whether every fault ended up covered. The choice is greedy and order-dependent, so the result is a valid cover but not necessarily the smallest one.

Top module: `greedy_cover_sel`

## Requirements
- R1: After reset, `selection` is all zeros and both `done` and `fullCover` are 0.
- R2: A `start` pulse clears the coverage register and `selection`, and lowers `done`, at the next clock edge.
- R3: For each accepted candidate, the decision bit is 1 exactly when the candidate has a set bit in a position where the coverage register is 0. That bit enters `selection[0]`, and every older bit moves up one place.
- R4: Each accepted candidate is ORed into the coverage register. A later candidate whose bits are all already covered therefore gets a decision of 0.
- R5: After n accepted candidates (n ≤ MAX_SPARES), `selection[n-1-k]` holds the decision for candidate k, counting from 0. When n equals MAX_SPARES, the first candidate sits in the most significant bit.
- R6: `done` rises at the clock edge that accepts a candidate with `rowLast` = 1. It stays high until the next `start`, and it is 0 while a pass is running.
- R7: `fullCover` is 1 only while `done` is 1, and only when every one of the FAULT_W coverage bits is 1.
- R8: A `rowValid` strobe given before the first `start`, or after `done` has risen, leaves `selection` and `done` unchanged.
- R9: When `start` and `rowValid` are high in the same cycle, the candidate is discarded and the pass starts with empty coverage.
- R10: When more than MAX_SPARES candidates are accepted, the decisions of the oldest candidates are shifted out of the top of `selection`, and only the newest MAX_SPARES decisions remain.
- R11: The selection is greedy. With 10 faults and 12 candidates, where the first five each cover a disjoint pair and together cover all ten, the result is 1 for the first five candidates and 0 for the other seven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new pass; clears coverage and selection |
| rowValid | input | 1 | Candidate on `rowData` is presented this cycle |
| rowData | input | FAULT_W | Faults this candidate spare can repair, one bit per fault |
| rowLast | input | 1 | Marks the final candidate of the pass |
| selection | output | MAX_SPARES | Decision bits; the newest candidate is at bit 0 |
| done | output | 1 | The pass has finished; held until the next start |
| fullCover | output | 1 | All faults are covered after the finished pass |

## Verification
The bench builds the block with FAULT_W = 10 and MAX_SPARES = 12. This lets it run the ten-fault, twelve-candidate greedy case exactly and also run passes longer than twelve candidates, which push decisions out of the top of the register. It sweeps every possible single candidate over all 1024 fault patterns, which exercises the all-covered flag at every coverage value. It also sweeps every ordered pair of candidates drawn from a 5-bit sub-space, which exercises whether the second decision sees the first candidate's coverage. Pseudo-random passes of 1 to 14 candidates, together with directed cases, cover the ignored-strobe and start-collision behaviour.

// File: rtl/cover_sel_pkg.sv
package cover_sel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } selState_t;

  // Strobes sent from the control to the datapath in one cycle
  typedef struct packed {
    logic clear;   // empty the coverage and selection registers
    logic accept;  // take the candidate on rowData this cycle
    logic finish;  // the accepted candidate is the final one
  } ctrlStrobe_t;

endpackage

// File: rtl/cover_sel_ctrl.sv
module cover_sel_ctrl
  import cover_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rowValid,
  input  logic        rowLast,
  output ctrlStrobe_t strobe,
  output logic        running,
  output logic        done
);

  selState_t state, stateNext;

  // start has priority; a candidate counts only inside a running pass
  always_comb begin
    strobe.clear  = start;
    strobe.accept = (state == ST_RUN) && rowValid && !start;
    strobe.finish = strobe.accept && rowLast;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_RUN;
      ST_RUN: begin
        if (start)              stateNext = ST_RUN;
        else if (strobe.finish) stateNext = ST_FIN;
      end
      ST_FIN:  if (start) stateNext = ST_RUN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign running = (state == ST_RUN);
  assign done    = (state == ST_FIN);

endmodule

// File: rtl/cover_sel_path.sv
module cover_sel_path
  import cover_sel_pkg::*;
#(
  parameter int FAULT_W    = 10,
  parameter int MAX_SPARES = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [FAULT_W-1:0]    rowData,
  output logic [MAX_SPARES-1:0] selection,
  output logic                  allCovered
);

  localparam int TOP = MAX_SPARES - 1;

  logic [FAULT_W-1:0] coverage;
  logic [FAULT_W-1:0] freshHit;
  logic               decision;

  // Per fault: this candidate reaches a fault that nothing covers yet
  for (genvar i = 0; i < FAULT_W; i++) begin : g_fresh
    assign freshHit[i] = rowData[i] & ~coverage[i];
  end

  assign decision   = |freshHit;
  assign allCovered = &coverage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coverage  <= '0;
      selection <= '0;
    end else if (strobe.clear) begin
      coverage  <= '0;
      selection <= '0;
    end else if (strobe.accept) begin
      coverage  <= coverage | rowData;
      selection <= {selection[TOP-1:0], decision};
    end
  end

endmodule

// File: rtl/greedy_cover_sel.sv
module greedy_cover_sel
  import cover_sel_pkg::*;
#(
  parameter int FAULT_W    = 10,
  parameter int MAX_SPARES = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  rowValid,
  input  logic [FAULT_W-1:0]    rowData,
  input  logic                  rowLast,
  output logic [MAX_SPARES-1:0] selection,
  output logic                  done,
  output logic                  fullCover
);

  ctrlStrobe_t strobe;
  logic        running;
  logic        allCovered;

  cover_sel_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rowValid (rowValid),
    .rowLast  (rowLast),
    .strobe   (strobe),
    .running  (running),
    .done     (done)
  );

  cover_sel_path #(
    .FAULT_W    (FAULT_W),
    .MAX_SPARES (MAX_SPARES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rowData    (rowData),
    .selection  (selection),
    .allCovered (allCovered)
  );

  assign fullCover = done & allCovered;

endmodule

// File: rtl/cover_sel_chk.sv
module cover_sel_chk #(
  parameter int FAULT_W    = 10,
  parameter int MAX_SPARES = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic                  rowValid,
  input logic [FAULT_W-1:0]    rowData,
  input logic                  rowLast,
  input logic                  running,
  input logic [MAX_SPARES-1:0] selection,
  input logic                  done,
  input logic                  fullCover
);

  // R1: reset state
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_r1: assert (selection == '0 && !done && !fullCover);
    end
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (selection == '0 && !done));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && rowValid && !start) |=>
      selection[MAX_SPARES-1:1] == $past(selection[MAX_SPARES-2:0]));

  p_empty_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && rowValid && !start && rowData == '0) |=> !selection[0]);

  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && rowValid && rowLast && !start) |=> done);

  p_done_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !done);

  p_full_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    fullCover |-> done);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> ($stable(selection) && $stable(done)));

  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && rowValid) |=> (selection == '0 && running));

endmodule

bind greedy_cover_sel cover_sel_chk #(
  .FAULT_W    (FAULT_W),
  .MAX_SPARES (MAX_SPARES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .rowValid  (rowValid),
  .rowData   (rowData),
  .rowLast   (rowLast),
  .running   (running),
  .selection (selection),
  .done      (done),
  .fullCover (fullCover)
);

// File: tb/sim_greedy_cover_sel.sv
module sim_greedy_cover_sel;

  localparam int FW = 10;
  localparam int MS = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          rowValid = 1'b0;
  logic [FW-1:0] rowData = '0;
  logic          rowLast = 1'b0;
  logic [MS-1:0] selection;
  logic          done;
  logic          fullCover;

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] rowsQ [0:31];
  logic [15:0]   lfsr = 16'hACE1;

  always #5 clk = ~clk;

  greedy_cover_sel #(.FAULT_W(FW), .MAX_SPARES(MS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rowValid(rowValid),
    .rowData(rowData), .rowLast(rowLast), .selection(selection),
    .done(done), .fullCover(fullCover)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Run one pass over rowsQ[0..n-1] and compare with an arithmetic model
  task automatic runSeq(input int n, input string req);
    logic [FW-1:0] expCov;
    logic [MS-1:0] expSel;
    logic          bitK;
    expCov = '0;
    expSel = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(selection == '0 && !done, "R2", "clear after start", selection, 0);
    for (int k = 0; k < n; k++) begin
      rowValid = 1'b1;
      rowData  = rowsQ[k];
      rowLast  = (k == n - 1);
      bitK     = ((rowsQ[k] & ~expCov) != '0);
      expCov   = expCov | rowsQ[k];
      expSel   = {expSel[MS-2:0], bitK};
      @(negedge clk);
      if (k != n - 1)
        check(!done, "R6", "done low mid-pass", done, 0);
    end
    rowValid = 1'b0;
    rowLast  = 1'b0;
    check(done, "R6", "done after last", done, 1);
    check(selection == expSel, req, "selection R3 R4", selection, expSel);
    check(fullCover == (expCov == '1), "R7", "fullCover", fullCover,
          longint'(expCov == '1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check(selection == '0 && !done && !fullCover, "R1", "reset outputs",
          selection, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R8 strobes before any start are ignored
    rowValid = 1'b1; rowData = '1; rowLast = 1'b1;
    repeat (2) @(negedge clk);
    rowValid = 1'b0; rowLast = 1'b0;
    check(selection == '0 && !done, "R8", "idle rows ignored", selection, 0);

    // R11 / R5: five disjoint column pairs then seven redundant rows
    for (int k = 0; k < 5; k++) rowsQ[k] = FW'(3) << (2 * k);
    for (int k = 5; k < 12; k++) rowsQ[k] = FW'(1) << (k - 3);
    runSeq(12, "R11");
    check(selection == 12'b1111_1000_0000, "R5", "first row at msb",
          selection, 12'hF80);
    check(fullCover, "R7", "example fully covered", fullCover, 1);

    // R8: rows after done leave the result alone
    rowValid = 1'b1; rowData = '1; rowLast = 1'b0;
    repeat (3) @(negedge clk);
    rowValid = 1'b0;
    check(selection == 12'hF80 && done, "R8", "post-done rows ignored",
          selection, 12'hF80);

    // R9: start with a valid row, that row must be discarded
    @(negedge clk); start = 1'b1; rowValid = 1'b1; rowData = '1;
    @(negedge clk); start = 1'b0; rowData = FW'(1); rowLast = 1'b1;
    @(negedge clk); rowValid = 1'b0; rowLast = 1'b0;
    check(selection == MS'(1), "R9", "collided row discarded", selection, 1);
    check(!fullCover && done, "R9", "coverage not from collided row",
          fullCover, 0);

    // R3 R7: every single candidate over all fault patterns
    for (int v = 0; v < (1 << FW); v++) begin
      rowsQ[0] = FW'(v);
      runSeq(1, "R3");
    end

    // R4: every ordered pair in a 5-bit sub-space
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) begin
        rowsQ[0] = FW'(a);
        rowsQ[1] = FW'(b);
        runSeq(2, "R4");
      end

    // R5 R10: pseudo-random passes of 1 to 14 candidates
    for (int s = 0; s < 300; s++) begin
      int n;
      lfsr = stepLfsr(lfsr);
      n = (lfsr % 14) + 1;
      for (int k = 0; k < n; k++) begin
        lfsr = stepLfsr(lfsr);
        rowsQ[k] = lfsr[FW-1:0] & FW'(lfsr >> 4) & FW'(lfsr >> 8);
      end
      runSeq(n, n > MS ? "R10" : "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule